// File: doc/BRIEF.md
# Signed-Magnitude Restoring Divider

This block divides a double-length magnitude by a single-length magnitude, with both operands in signed-magnitude form. The caller presents a dividend sign and a 2N-bit dividend magnitude, plus a divisor sign and an N-bit divisor magnitude, and pulses `start`. The block returns an N-bit quotient magnitude with its own sign and an N-bit remainder magnitude whose sign follows the dividend.

The upper half of the dividend is first compared with the divisor. If the upper half is not smaller, the quotient would not fit in N bits. The block then raises `overflow` and finishes at once. Otherwise it runs N shift-and-subtract steps. Each step shifts the working pair left by one bit and keeps the bit that falls out of the top. If that bit is 1, the divisor is subtracted without a compare. If it is 0, a trial subtraction decides the quotient bit, and a failed trial leaves the partial remainder as it was.

`done` pulses for one cycle at the end of either path. The results stay on the outputs until the next accepted start.

Top module: `smag_div`

## Requirements
- R1: After reset, `done`, `overflow`, `quotient`, `quotientSign`, `remainder` and `remainderSign` are all 0.
- R2: When `done` is 1, `quotientSign` equals `dividendSign` XOR `divisorSign`, and `remainderSign` equals `dividendSign`.
- R3: If the upper N bits of the dividend magnitude (bits 2N-1..N) are greater than or equal to the divisor, the operation ends early. `overflow` is 1 and `done` is 1 in the cycle that follows the first rising edge after the edge that samples `start`.
- R4: Otherwise `overflow` is 0, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both on magnitudes.
- R5: `done` is a one-cycle pulse. On a normal division it is 1 in the cycle that follows the (N+1)th rising edge after the edge that samples `start`.
- R6: `start` is accepted only while the block is idle. A `start` raised during an operation produces no extra `done` pulse and does not change that operation's results.
- R7: After `done`, all result outputs hold their values until the next accepted `start`, whatever the operand inputs do.
- R8: A dividend whose working remainder shifts a 1 out of its top bit still gives the correct quotient and remainder. An example is a divisor with its top bit set and an upper half just below it.
- R9: A zero divisor always ends in overflow under R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| dividendSign | input | 1 | Dividend sign, 1 = negative |
| dividendMag | input | 2N | Dividend magnitude |
| divisorSign | input | 1 | Divisor sign, 1 = negative |
| divisorMag | input | N | Divisor magnitude |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Divide overflow, set when the operation ended early |
| quotient | output | N | Quotient magnitude |
| quotientSign | output | 1 | Quotient sign |
| remainder | output | N | Remainder magnitude |
| remainderSign | output | 1 | Remainder sign |

## Verification
The hardest path to reach from the ports is a step where a 1 leaves the top of the working remainder. Only then is the quotient bit set without a trial compare. This needs a divisor with its top bit set and an upper dividend half just below that divisor. The stimulus builds such operands directly (for example divisor 0xF0 with upper half 0xEF) and also mixes them into a seeded pseudo-random run. A behavioural model compares `done` on every clock against the expected latency. Overflow boundaries (upper half equal to the divisor, zero divisor) and a `start` raised mid-operation are aimed at specifically.

// File: rtl/smag_div_pkg.sv
package smag_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOOP  = 2'd2,
    ST_DONE  = 2'd3
  } divState_t;

  typedef struct packed {
    logic load;     // capture operands and signs
    logic step;     // one shift/subtract step
    logic flagOvf;  // record divide overflow
  } divStrobes_t;

endpackage

// File: rtl/smag_div_ctrl.sv
module smag_div_ctrl
  import smag_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        ovfDetect,
  output divStrobes_t strobes,
  output logic        done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] STEPS = CW'(N);

  divState_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes.load    = (state == ST_IDLE) && start;
    strobes.flagOvf = (state == ST_CHECK) && ovfDetect;
    strobes.step    = (state == ST_LOOP);
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_CHECK;
        ST_CHECK: begin
          if (ovfDetect) state <= ST_DONE;
          else begin
            state   <= ST_LOOP;
            stepCnt <= STEPS;
          end
        end
        ST_LOOP: begin
          stepCnt <= stepCnt - 1'b1;
          if (stepCnt == CW'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_OVF_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && ovfDetect) |=> done); // R3

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOP && stepCnt > CW'(1)) |=> (state == ST_LOOP)); // R6

endmodule

// File: rtl/smag_div_path.sv
module smag_div_path
  import smag_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobes_t   strobes,
  input  logic          dividendSign,
  input  logic [2*N-1:0] dividendMag,
  input  logic          divisorSign,
  input  logic [N-1:0]  divisorMag,
  output logic          ovfDetect,
  output logic [N-1:0]  quotient,
  output logic          quotientSign,
  output logic [N-1:0]  remainder,
  output logic          remainderSign,
  output logic          overflow
);

  logic [N-1:0] regA, regQ, regB;
  logic         qSign, rSign, dvf;

  // Overflow pre-check: A + ~B + 1, carry out means A >= B.
  // A itself is never written, so nothing needs adding back.
  logic [N:0] preDiff;
  assign preDiff   = {1'b0, regA} + {1'b0, ~regB} + {{N{1'b0}}, 1'b1};
  assign ovfDetect = preDiff[N];

  // One step: shift E:A:Q left, then subtract or keep.
  logic         eBit;
  logic [N-1:0] shA, shQ, nextA;
  logic [N:0]   trial;
  logic         takeBit;

  always_comb begin
    eBit    = regA[N-1];
    shA     = {regA[N-2:0], regQ[N-1]};
    shQ     = {regQ[N-2:0], 1'b0};
    trial   = {1'b0, shA} + {1'b0, ~regB} + {{N{1'b0}}, 1'b1};
    takeBit = eBit | trial[N];
    nextA   = takeBit ? trial[N-1:0] : shA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA  <= '0;
      regQ  <= '0;
      regB  <= '0;
      qSign <= 1'b0;
      rSign <= 1'b0;
      dvf   <= 1'b0;
    end else if (strobes.load) begin
      regA  <= dividendMag[2*N-1:N];
      regQ  <= dividendMag[N-1:0];
      regB  <= divisorMag;
      qSign <= dividendSign ^ divisorSign;
      rSign <= dividendSign;
      dvf   <= 1'b0;
    end else if (strobes.flagOvf) begin
      dvf <= 1'b1;
    end else if (strobes.step) begin
      regA <= nextA;
      regQ <= {shQ[N-1:1], takeBit};
    end
  end

  assign quotient      = regQ;
  assign remainder     = regA;
  assign quotientSign  = qSign;
  assign remainderSign = rSign;
  assign overflow      = dvf;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (regA < regB)); // R4

  AST_EBIT_QUOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && eBit) |=> regQ[0]); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(regA) && $stable(regQ) && $stable(qSign))); // R7

  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (qSign == ($past(dividendSign) ^ $past(divisorSign)))); // R2

  AST_ZERO_DIV_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (regB == '0) |-> ovfDetect); // R9

endmodule

// File: rtl/smag_div.sv
module smag_div
  import smag_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           dividendSign,
  input  logic [2*N-1:0] dividendMag,
  input  logic           divisorSign,
  input  logic [N-1:0]   divisorMag,
  output logic           done,
  output logic           overflow,
  output logic [N-1:0]   quotient,
  output logic           quotientSign,
  output logic [N-1:0]   remainder,
  output logic           remainderSign
);

  divStrobes_t strobes;
  logic        ovfDetect;

  smag_div_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ovfDetect (ovfDetect),
    .strobes   (strobes),
    .done      (done)
  );

  smag_div_path #(.N(N)) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .dividendSign  (dividendSign),
    .dividendMag   (dividendMag),
    .divisorSign   (divisorSign),
    .divisorMag    (divisorMag),
    .ovfDetect     (ovfDetect),
    .quotient      (quotient),
    .quotientSign  (quotientSign),
    .remainder     (remainder),
    .remainderSign (remainderSign),
    .overflow      (overflow)
  );

endmodule

// File: tb/test_smag_div.sv
module test_smag_div;

  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           dividendSign = 1'b0;
  logic [2*N-1:0] dividendMag = '0;
  logic           divisorSign = 1'b0;
  logic [N-1:0]   divisorMag = '0;
  logic           done, overflow, quotientSign, remainderSign;
  logic [N-1:0]   quotient, remainder;

  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  smag_div #(.N(N)) i_smag_div (
    .clk(clk), .rstN(rstN), .start(start),
    .dividendSign(dividendSign), .dividendMag(dividendMag),
    .divisorSign(divisorSign), .divisorMag(divisorMag),
    .done(done), .overflow(overflow),
    .quotient(quotient), .quotientSign(quotientSign),
    .remainder(remainder), .remainderSign(remainderSign)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Behavioural model: expected results and latency from the requirements.
  task automatic runOp(input bit ds, input longint dmag, input bit bs, input longint bmag,
                       input bit poke, input string req);
    longint upper, q, r;
    bit     ovf;
    int     lat;
    upper = dmag >> N;
    ovf   = (upper >= bmag);               // R3, R9
    lat   = ovf ? 1 : N + 1;               // R3, R5
    q = 0; r = 0;
    if (!ovf) begin q = dmag / bmag; r = dmag % bmag; end  // R4
    @(negedge clk);
    dividendSign = ds; dividendMag = (2*N)'(dmag);
    divisorSign  = bs; divisorMag  = N'(bmag);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= lat + 3; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cyc == lat ? "R5" : "R6", "done per clock", done, cyc == lat);
      if (cyc >= lat) begin
        chk(req, "overflow", overflow, ovf);
        chk("R2", "quotientSign", quotientSign, ds ^ bs);
        chk("R2", "remainderSign", remainderSign, ds);
        if (!ovf) begin
          chk(cyc == lat ? req : "R7", "quotient", quotient, q);
          chk(cyc == lat ? req : "R7", "remainder", remainder, r);
        end
      end
      if (poke && cyc == 2) begin        // R6: start during an operation
        start = 1'b1;
        dividendMag = '0; divisorMag = 8'd3; dividendSign = ~ds;
      end
      if (cyc == 3) start = 1'b0;
      if (cyc == lat) begin              // R7: scramble inputs without start
        dividendMag = (2*N)'(nextRand()); divisorMag = N'(nextRand());
        dividendSign = ~ds; divisorSign = ~bs;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "done", done, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "quotient", quotient, 0);
    chk("R1", "remainder", remainder, 0);
    chk("R1", "quotientSign", quotientSign, 0);
    chk("R1", "remainderSign", remainderSign, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(0, 100, 0, 7, 0, "R4");
    runOp(1, 1000, 0, 13, 0, "R4");
    runOp(0, 255, 1, 1, 0, "R4");
    runOp(1, 16'h7FFF, 1, 8'h80, 0, "R4");
    runOp(0, 16'h0500, 0, 8'h05, 0, "R3");   // upper half equal: overflow
    runOp(1, 16'h0600, 0, 8'h05, 0, "R3");
    runOp(0, 16'h1234, 1, 8'h00, 0, "R9");   // zero divisor
    runOp(0, 16'h0000, 0, 8'h00, 0, "R9");
    runOp(0, 16'hEFFF, 0, 8'hF0, 0, "R8");   // top bit shifts out
    runOp(1, 16'hFEAB, 1, 8'hFF, 0, "R8");
    runOp(0, 5000, 0, 77, 1, "R6");          // start raised mid-operation
    for (int k = 0; k < 40; k++) begin
      longint bm, dm;
      bm = nextRand() % 256;
      dm = nextRand() % 65536;
      if (k % 3 == 0) begin bm = bm | 128; dm = ((bm - 1) << 8) | (nextRand() % 256); end
      runOp(nextRand() % 2 == 1, dm, nextRand() % 2 == 1, bm, 0, k % 3 == 0 ? "R8" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule